// File: doc/BRIEF.md
# Oscillator Stop Detection Monitor

This block watches an external clock that it does not run from and raises an alarm when that clock stalls. It runs on a free-running backup clock, which keeps going when the monitored clock dies. The monitored clock passes through a synchronizer into the backup domain. Every backup cycle without a level change on it advances a no-change counter. When the counter reaches the `TIMEOUT` parameter, a sticky stop-status bit is set. Only a power-on reset or an exit from software standby clears it.

Two register bits decide what the status drives. The flag-enable bit routes the status to a dedicated alarm output. The float-enable bit asserts a force signal that puts a group of high-current pins into high impedance, overriding their pin-function setting. That force signal is also asserted during software standby. While standby is active, detection is suspended, because the clock is stopped on purpose and must not raise a false alarm. Software sets the two enable bits through a simple write port and reads them back, together with the status bit, on a read bus.

Top module: `osc_stop_monitor`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `stop_status`, `stop_flag`, `hiz_force` and `rd_data` are all 0.
- R2: Let E be the first backup-clock edge after the monitored clock's last level change. If no further change follows, `stop_status` reads 0 after edge E+`TIMEOUT`+2 and reads 1 after edge E+`TIMEOUT`+3.
- R3: Once set, `stop_status` stays 1 even when the monitored clock starts toggling again.
- R4: A one-cycle pulse on `standby_exit` clears `stop_status` on that edge. `rst` clears it and both enable bits.
- R5: `stop_flag` equals `stop_status` AND the flag-enable bit (`rd_data[0]`), and changes on the same edge as `stop_status`.
- R6: `hiz_force` goes to the float-enable bit (`rd_data[1]`) AND (`stop_status` OR `standby`) on the edge after `standby` changes. It goes low again on the edge where standby is left with status clear.
- R7: While `standby` is 1, the no-change counter is held at zero and `stop_status` is never set, however long the monitored clock is static.
- R8: When `wr_en` is 1, `wr_data[0]` loads the flag-enable bit and `wr_data[1]` loads the float-enable bit on that edge. `rd_data` = {`stop_status`, float-enable, flag-enable}, and software writes have no effect on bit 2.
- R9: Two monitored-clock changes whose first backup edges are g cycles apart set `stop_status` exactly when g ≥ `TIMEOUT`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bk | input | 1 | Free-running backup clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| mon_clk | input | 1 | Monitored clock, asynchronous to clk_bk |
| standby | input | 1 | Software standby is active |
| standby_exit | input | 1 | One-cycle pulse when standby is cancelled |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 2 | bit0 flag-enable, bit1 float-enable |
| rd_data | output | 3 | {stop status, float-enable, flag-enable} |
| stop_status | output | 1 | Sticky stop-detected bit |
| stop_flag | output | 1 | Alarm pin drive |
| hiz_force | output | 1 | Forces high-current pins to high impedance |

## Verification
The monitored clock takes two edges to pass the synchronizer and one more to reach the edge detector. The counter then needs `TIMEOUT` edges to saturate, and the status register takes one further edge. The bench therefore samples the status at exactly edge E+`TIMEOUT`+2 and E+`TIMEOUT`+3. The flag, the force output and the clear by standby exit all land on the same edge as their cause, and an enable write reaches the outputs one edge later. The bench drives every input on the falling edge and samples just before the next rising edge. It sweeps the toggle gap from 1 to `TIMEOUT`+3 cycles, so the threshold is hit on both sides.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;
  typedef struct packed {
    logic hz_en;
    logic oe_en;
  } osc_ctrl_t;
  localparam int CTRL_W = $bits(osc_ctrl_t);
  localparam int RD_W   = CTRL_W + 1;
endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic edge_o
);
  localparam int MSB = SYNC_STAGES - 1;
  logic [MSB:0] sh_q;
  logic         prev_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[MSB-1:0], async_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= async_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sh_q[MSB];
  end

  assign edge_o = sh_q[MSB] ^ prev_q;

  // R9: after an edge is taken, prev tracks the synchronized value
  p_edge_track_r9: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> (prev_q == $past(sh_q[MSB])));
endmodule

// File: rtl/osc_stall_timer.sv
module osc_stall_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic expired_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)       cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (expired_o && !clr_i) |=> expired_o);
  p_cnt_clr_r7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/osc_ctrl_regs.sv
module osc_ctrl_regs
  import osc_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              expired_i,
  input  logic              standby,
  input  logic              standby_exit,
  output logic [RD_W-1:0]   rd_data,
  output logic              status_o,
  output logic              flag_o,
  output logic              hiz_o
);
  osc_ctrl_t ctrl_q;
  logic      status_q, status_d, flag_q, hiz_q;

  always_comb begin
    if (standby_exit) status_d = 1'b0;
    else              status_d = status_q | (expired_i & ~standby);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      status_q <= 1'b0;
      flag_q   <= 1'b0;
      hiz_q    <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= osc_ctrl_t'(wr_data);
      status_q <= status_d;
      flag_q   <= ctrl_q.oe_en & status_d;
      hiz_q    <= ctrl_q.hz_en & (status_d | standby);
    end
  end

  assign rd_data  = {status_q, ctrl_q};
  assign status_o = status_q;
  assign flag_o   = flag_q;
  assign hiz_o    = hiz_q;

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (status_q && !standby_exit) |=> status_q);
  p_exit_clr_r4: assert property (@(posedge clk) disable iff (rst)
    standby_exit |=> !status_q);
  p_flag_status_r5: assert property (@(posedge clk) disable iff (rst)
    flag_o |-> status_q);
  p_hiz_en_r6: assert property (@(posedge clk) disable iff (rst)
    hiz_o |-> $past(ctrl_q.hz_en));
  p_no_set_standby_r7: assert property (@(posedge clk) disable iff (rst)
    (standby && !status_q) |=> !status_q);
endmodule

// File: rtl/osc_stop_monitor.sv
module osc_stop_monitor
  import osc_mon_pkg::*;
#(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_bk,
  input  logic              rst,
  input  logic              mon_clk,
  input  logic              standby,
  input  logic              standby_exit,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [RD_W-1:0]   rd_data,
  output logic              stop_status,
  output logic              stop_flag,
  output logic              hiz_force
);
  logic mon_edge, expired;

  osc_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_bk), .rst(rst), .async_i(mon_clk), .edge_o(mon_edge)
  );

  osc_stall_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk_bk), .rst(rst), .clr_i(mon_edge | standby), .expired_o(expired)
  );

  osc_ctrl_regs u_regs (
    .clk(clk_bk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .expired_i(expired), .standby(standby), .standby_exit(standby_exit),
    .rd_data(rd_data), .status_o(stop_status), .flag_o(stop_flag),
    .hiz_o(hiz_force)
  );
endmodule

// File: tb/tb_osc_stop_monitor.sv
module tb_osc_stop_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int T = 16;

  logic clk = 1'b0, rst = 1'b1, mon = 1'b0, sb = 1'b0, sbx = 1'b0, wr = 1'b0;
  logic [1:0] wd = '0;
  logic [2:0] rd;
  logic st, fl, hz;
  int total = 0, bad = 0;
  bit done = 0;

  osc_stop_monitor #(.TIMEOUT(T)) dut (
    .clk_bk(clk), .rst(rst), .mon_clk(mon), .standby(sb), .standby_exit(sbx),
    .wr_en(wr), .wr_data(wd), .rd_data(rd), .stop_status(st),
    .stop_flag(fl), .hiz_force(hz)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic toggle_ticks(input int n);
    for (int i = 0; i < n; i++) begin mon = ~mon; tick(); end
  endtask

  task automatic clear_status();
    toggle_ticks(2);
    sbx = 1'b1; mon = ~mon; tick(); sbx = 1'b0;
    toggle_ticks(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk({st, fl, hz}, 3'b000, "R1 during reset");
    tick(); tick();
    rst = 1'b0;
    tick();
    chk({st, fl, hz}, 3'b000, "R1 outputs after reset");
    chk(rd, 3'b000, "R1 rd_data after reset");

    // R8 register write / readback
    wr = 1'b1; wd = 2'b10; toggle_ticks(1); wr = 1'b0;
    chk(rd, 3'b010, "R8 float-enable only");
    wr = 1'b1; wd = 2'b11; toggle_ticks(1); wr = 1'b0;
    chk(rd, 3'b011, "R8 both enables");

    // R9 sweep of toggle gaps
    for (int g = 1; g <= T + 3; g++) begin
      clear_status();
      chk({2'b00, st}, 3'b000, "R4 cleared before gap");
      mon = ~mon;
      for (int i = 0; i < g; i++) tick();
      toggle_ticks(4);
      chk({2'b00, st}, {2'b00, (g >= T + 1)}, "R9 gap sweep status");
      chk({st, fl, hz}, {3{(g >= T + 1)}}, "R5 R6 flag/force follow status");
    end

    // R2 exact timing
    clear_status();
    mon = ~mon;
    for (int i = 0; i < T + 3; i++) tick();
    chk({2'b00, st}, 3'b000, "R2 one edge early");
    tick();
    chk({st, fl, hz}, 3'b111, "R2 R5 R6 set on time");

    // R3 sticky across resumed toggling
    toggle_ticks(6);
    chk({2'b00, st}, 3'b001, "R3 status sticky");

    // R5 flag-enable off
    wr = 1'b1; wd = 2'b10; toggle_ticks(1); wr = 1'b0;
    toggle_ticks(1);
    chk({st, fl, hz}, 3'b101, "R5 flag masked");
    chk(rd, 3'b110, "R8 readback with status");

    // R4 standby exit clears
    sbx = 1'b1; mon = ~mon; tick(); sbx = 1'b0;
    chk({st, fl, hz}, 3'b000, "R4 exit clears status");

    // R7 standby: no detection, force asserted
    sb = 1'b1; tick();
    chk({st, fl, hz}, 3'b001, "R6 standby forces float");
    for (int i = 0; i < T + 10; i++) tick();
    chk({st, fl, hz}, 3'b001, "R7 no detection in standby");
    sb = 1'b0; sbx = 1'b1; tick(); sbx = 1'b0;
    chk({st, fl, hz}, 3'b000, "R6 force released on exit");
    toggle_ticks(4);
    chk({2'b00, st}, 3'b000, "R7 no stale stall after standby");

    // R4 reset clears status and enables
    for (int i = 0; i < T + 6; i++) tick();
    chk(rd, 3'b110, "R2 stall detected again");
    rst = 1'b1; tick(); rst = 1'b0;
    chk(rd, 3'b000, "R4 reset clears status and enables");
    chk({st, fl, hz}, 3'b000, "R4 reset clears outputs");

    finish_run();
  end
endmodule